// File: doc/BRIEF.md
# Interrupt Line Error Injector

This block sits in front of an interrupt distributor and lets test agents force chosen peripheral interrupt lines high without touching the sources that drive them. Every incoming line is captured in a flop each cycle. The low part of the line vector is the injectable peripheral range, which by default is five 32-bit words or 160 lines. For each line in that range the block drives the captured level ORed with the matching bit of every injector's mask bank. Lines above the range are captured and forwarded with no change.

Each injector agent owns one bank of mask words, one word per word index. A small register port replaces one whole mask word, chosen by injector and word index, in one write. It can also read any mask word back. A write takes effect on all 32 lines of its word in the next cycle, whether or not those inputs moved. A write to a word index outside the range changes nothing and raises an error flag for exactly one cycle. The register port is plain control: it has no back-pressure, and every strobe is accepted in the cycle it is presented.

Top module: `irq_fault_inject`

## Requirements
- R1: After reset every output line, `cfg_rdata` and `cfg_err` are 0, and every mask word of every injector reads back as 0.
- R2: Peripheral line n is controlled by bit n%32 of mask word n/32. Writing a word with only bit b set drives line 32*idx+b high one cycle after the write, while its input stays low, and leaves every other line at its input level.
- R3: Each peripheral output equals the input level captured at the previous clock edge, ORed with the matching mask bit of every injector. A change on an input appears at the output exactly one cycle later.
- R4: A mask write replaces the whole 32-bit word, so bits set by an earlier write to the same word and injector are cleared.
- R5: After a mask write, the outputs of all 32 lines of that word reflect the new mask one cycle after the write, even when no input changed.
- R6: Lines at index 160 and above (default `NUM_BYPASS` = 32) show their input level one cycle later and are never affected by any mask.
- R7: A write with a word index of 5 or more changes no mask word and no output, and `cfg_err` is 1 in exactly the cycle after that write. In every other cycle `cfg_err` is 0.
- R8: A read strobe returns the selected mask word on `cfg_rdata` one cycle later. A read with a word index of 5 or more returns 0. A read in the same cycle as a write to the same word returns the old value. Without a read strobe, `cfg_rdata` holds its value.
- R9: Injector banks are independent: clearing a word in one bank leaves the bits forced by the other bank in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 192 | Raw interrupt levels; bits 0..159 are injectable, 160..191 bypass |
| cfg_wr_en | input | 1 | Mask word write strobe |
| cfg_rd_en | input | 1 | Mask word read strobe |
| cfg_sel | input | 1 | Injector select |
| cfg_idx | input | 3 | Mask word index, legal 0..4 |
| cfg_wdata | input | 32 | Mask word write data |
| cfg_rdata | output | 32 | Read-back data, valid the cycle after a read strobe |
| cfg_err | output | 1 | One-cycle pulse after a write with an illegal index |
| irq_out | output | 192 | Combined levels to the downstream distributor |

## Verification
The assertions assume that `irq_in` and the register strobes change only between clock edges and are never unknown after reset, so that the previous sampled value of a pin is what the block captured. They also assume that a read and a write may coincide but carry the same select and index. The stimulus drives every input just after a falling edge from a single process, holds it for a full cycle, and keeps every pin at a defined value from time zero.

// File: rtl/ifi_pkg.sv
package ifi_pkg;
  localparam int unsigned DEF_WORD_W    = 32;
  localparam int unsigned DEF_NUM_WORDS = 5;
  localparam int unsigned DEF_NUM_INJ   = 2;
  localparam int unsigned DEF_BYPASS    = 32;

  function automatic int unsigned clog2_min1(input int unsigned v);
    int unsigned r;
    r = (v <= 1) ? 1 : $clog2(v);
    return r;
  endfunction
endpackage

// File: rtl/ifi_level_latch.sv
module ifi_level_latch #(
  parameter int unsigned WIDTH = 192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] lvl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_i;
  end
endmodule

// File: rtl/ifi_mask_bank.sv
module ifi_mask_bank #(
  parameter int unsigned NUM_WORDS = 5,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned IDX_W     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [IDX_W-1:0]            widx,
  input  logic [WORD_W-1:0]           wdata,
  output logic [NUM_WORDS*WORD_W-1:0] mask_flat
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= '0;
      else if (we && (int'(widx) == w))
        word_q <= wdata;
    end
    assign mask_flat[w*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/ifi_cfg_port.sv
module ifi_cfg_port #(
  parameter int unsigned NUM_INJ   = 2,
  parameter int unsigned NUM_WORDS = 5,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned SEL_W     = 1,
  parameter int unsigned IDX_W     = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic                                rd_en,
  input  logic [SEL_W-1:0]                    sel,
  input  logic [IDX_W-1:0]                    idx,
  input  logic [NUM_INJ*NUM_WORDS*WORD_W-1:0] masks_flat,
  output logic [NUM_INJ-1:0]                  bank_we,
  output logic [WORD_W-1:0]                   rdata,
  output logic                                err
);
  logic idx_ok;
  logic [WORD_W-1:0] rd_word;

  assign idx_ok = (int'(idx) < NUM_WORDS);

  for (genvar b = 0; b < NUM_INJ; b++) begin : g_we
    assign bank_we[b] = wr_en && idx_ok && (int'(sel) == b);
  end

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NUM_INJ; b++) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if ((int'(sel) == b) && (int'(idx) == w))
          rd_word = masks_flat[(b*NUM_WORDS + w)*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      err <= wr_en && !idx_ok;
      if (rd_en) rdata <= rd_word;
    end
  end
endmodule

// File: rtl/irq_fault_inject.sv
module irq_fault_inject
  import ifi_pkg::*;
#(
  parameter int unsigned NUM_INJ    = DEF_NUM_INJ,
  parameter int unsigned NUM_WORDS  = DEF_NUM_WORDS,
  parameter int unsigned WORD_W     = DEF_WORD_W,
  parameter int unsigned NUM_BYPASS = DEF_BYPASS,
  localparam int unsigned NUM_PERIPH = NUM_WORDS * WORD_W,
  localparam int unsigned NUM_LINES  = NUM_PERIPH + NUM_BYPASS,
  localparam int unsigned SEL_W      = clog2_min1(NUM_INJ),
  localparam int unsigned IDX_W      = clog2_min1(NUM_WORDS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 cfg_wr_en,
  input  logic                 cfg_rd_en,
  input  logic [SEL_W-1:0]     cfg_sel,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic [WORD_W-1:0]    cfg_wdata,
  output logic [WORD_W-1:0]    cfg_rdata,
  output logic                 cfg_err,
  output logic [NUM_LINES-1:0] irq_out
);
  logic [NUM_LINES-1:0]                  level_q;
  logic [NUM_INJ-1:0]                    bank_we;
  logic [NUM_INJ*NUM_PERIPH-1:0]         masks_flat;
  logic [NUM_PERIPH-1:0]                 forced;

  ifi_level_latch #(.WIDTH(NUM_LINES)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (irq_in),
    .lvl_q (level_q)
  );

  for (genvar b = 0; b < NUM_INJ; b++) begin : g_bank
    ifi_mask_bank #(
      .NUM_WORDS (NUM_WORDS),
      .WORD_W    (WORD_W),
      .IDX_W     (IDX_W)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (bank_we[b]),
      .widx      (cfg_idx),
      .wdata     (cfg_wdata),
      .mask_flat (masks_flat[b*NUM_PERIPH +: NUM_PERIPH])
    );
  end

  ifi_cfg_port #(
    .NUM_INJ   (NUM_INJ),
    .NUM_WORDS (NUM_WORDS),
    .WORD_W    (WORD_W),
    .SEL_W     (SEL_W),
    .IDX_W     (IDX_W)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_wr_en),
    .rd_en      (cfg_rd_en),
    .sel        (cfg_sel),
    .idx        (cfg_idx),
    .masks_flat (masks_flat),
    .bank_we    (bank_we),
    .rdata      (cfg_rdata),
    .err        (cfg_err)
  );

  // OR of every injector bank over the peripheral range
  always_comb begin
    forced = '0;
    for (int b = 0; b < NUM_INJ; b++)
      forced = forced | masks_flat[b*NUM_PERIPH +: NUM_PERIPH];
  end

  assign irq_out = {level_q[NUM_LINES-1:NUM_PERIPH], level_q[NUM_PERIPH-1:0] | forced};
endmodule

// File: rtl/ifi_checker.sv
module ifi_checker #(
  parameter int unsigned NUM_WORDS  = 5,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned NUM_BYPASS = 32,
  parameter int unsigned SEL_W      = 1,
  parameter int unsigned IDX_W      = 3,
  localparam int unsigned NP = NUM_WORDS * WORD_W,
  localparam int unsigned NL = NP + NUM_BYPASS
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NL-1:0]     irq_in,
  input logic              cfg_wr_en,
  input logic              cfg_rd_en,
  input logic [IDX_W-1:0]  cfg_idx,
  input logic [WORD_W-1:0] cfg_rdata,
  input logic              cfg_err,
  input logic [NL-1:0]     irq_out
);
  logic pv;
  logic bad_wr, bad_rd;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv <= 1'b0;
    else        pv <= 1'b1;
  end
  assign bad_wr = cfg_wr_en && (int'(cfg_idx) >= NUM_WORDS);
  assign bad_rd = cfg_rd_en && (int'(cfg_idx) >= NUM_WORDS);

  AST_ERR_AFTER_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> cfg_err); // R7
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_wr |=> !cfg_err); // R7
  AST_BYPASS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    pv |-> (irq_out[NL-1:NP] == $past(irq_in[NL-1:NP]))); // R6
  AST_LEVEL_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    pv |-> ((irq_out[NP-1:0] & $past(irq_in[NP-1:0])) == $past(irq_in[NP-1:0]))); // R3
  AST_RD_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $past(bad_rd)) |-> (cfg_rdata == '0)); // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && !$past(cfg_rd_en)) |-> $stable(cfg_rdata)); // R8
endmodule

bind irq_fault_inject ifi_checker #(
  .NUM_WORDS  (NUM_WORDS),
  .WORD_W     (WORD_W),
  .NUM_BYPASS (NUM_BYPASS),
  .SEL_W      (SEL_W),
  .IDX_W      (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_in    (irq_in),
  .cfg_wr_en (cfg_wr_en),
  .cfg_rd_en (cfg_rd_en),
  .cfg_idx   (cfg_idx),
  .cfg_rdata (cfg_rdata),
  .cfg_err   (cfg_err),
  .irq_out   (irq_out)
);

// File: tb/irq_fault_inject_tb.sv
`timescale 1ns/1ps
module irq_fault_inject_tb;
  localparam int NL = 192;
  localparam int NP = 160;
  localparam int NW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] irq_in = '0;
  logic          cfg_wr_en = 1'b0;
  logic          cfg_rd_en = 1'b0;
  logic          cfg_sel = 1'b0;
  logic [2:0]    cfg_idx = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic          cfg_err;
  logic [NL-1:0] irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] mdl [2][NW];

  always #10 clk = ~clk;

  irq_fault_inject u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_err(cfg_err), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [NL-1:0] act, input logic [NL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NL-1:0] exp_out();
    logic [NL-1:0] e;
    e = irq_in;
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < NW; w++)
        e[w*32 +: 32] = e[w*32 +: 32] | mdl[s][w];
    return e;
  endfunction

  task automatic wr(input int s, input int i, input logic [31:0] d);
    cfg_wr_en = 1'b1; cfg_sel = s[0]; cfg_idx = i[2:0]; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    if (i < NW) mdl[s][i] = d;
  endtask

  task automatic rd(input int s, input int i);
    cfg_rd_en = 1'b1; cfg_sel = s[0]; cfg_idx = i[2:0];
    @(negedge clk);
    cfg_rd_en = 1'b0;
  endtask

  task automatic check_all_words(input string tag);
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < NW; w++) begin
        rd(s, w);
        chk(tag, NL'(cfg_rdata), NL'(mdl[s][w]));
      end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] old;
    for (int s = 0; s < 2; s++) for (int w = 0; w < NW; w++) mdl[s][w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 out", irq_out, '0);
    chk("R1 rdata", NL'(cfg_rdata), '0);
    chk("R1 err", NL'(cfg_err), '0);
    check_all_words("R1 mask readback");

    // R2 / R4 / R5: walking single bit through every word of every bank
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < NW; w++) begin
        for (int b = 0; b < 32; b++) begin
          wr(s, w, 32'h1 << b);
          chk("R2 R5 walking bit", irq_out, exp_out());
        end
        wr(s, w, 32'h0);
        chk("R4 word replaced", irq_out, exp_out());
      end

    // R3: random inputs under a fixed mask pattern
    wr(0, 1, 32'hA5A5_0F0F);
    wr(1, 3, 32'h0000_FFFF);
    for (int k = 0; k < 40; k++) begin
      irq_in = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      @(negedge clk);
      chk("R3 combine", irq_out, exp_out());
    end
    // R3 single input edge appears one cycle later
    irq_in = '0;
    @(negedge clk);
    irq_in[7] = 1'b1;
    @(negedge clk);
    chk("R3 edge latency", NL'(irq_out[7]), NL'(1));
    irq_in[7] = 1'b0;
    @(negedge clk);
    chk("R3 fall latency", NL'(irq_out[7]), NL'(0));

    // R6: all masks set, bypass lines still raw
    for (int s = 0; s < 2; s++) for (int w = 0; w < NW; w++) wr(s, w, 32'hFFFF_FFFF);
    for (int k = 0; k < 20; k++) begin
      irq_in = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      @(negedge clk);
      chk("R6 bypass", irq_out, exp_out());
      chk("R6 bypass raw", NL'(irq_out[NL-1:NP]), NL'(irq_in[NL-1:NP]));
    end

    // R7: illegal index writes
    irq_in = '0;
    wr(0, 2, 32'h1234_5678);
    wr(1, 4, 32'h8000_0001);
    for (int i = NW; i < 8; i++) begin
      wr(i % 2, i, 32'hDEAD_BEEF);
      chk("R7 err pulse", NL'(cfg_err), NL'(1));
      chk("R7 out unchanged", irq_out, exp_out());
      @(negedge clk);
      chk("R7 err cleared", NL'(cfg_err), NL'(0));
    end
    wr(0, 0, 32'h0000_00F0);
    chk("R7 no err on legal", NL'(cfg_err), NL'(0));
    check_all_words("R7 masks untouched");

    // R8: read-back of distinct values
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < NW; w++)
        wr(s, w, 32'h1111_1111 * (w + 1) ^ (s ? 32'hF0F0_0000 : 32'h0000_0F0F));
    check_all_words("R8 readback");
    rd(0, 6);
    chk("R8 oor read", NL'(cfg_rdata), '0);
    rd(1, 2);
    old = cfg_rdata;
    @(negedge clk); @(negedge clk);
    chk("R8 hold", NL'(cfg_rdata), NL'(old));
    // same-cycle write and read of one word returns old value
    cfg_wr_en = 1'b1; cfg_rd_en = 1'b1; cfg_sel = 1'b1; cfg_idx = 3'd2; cfg_wdata = 32'hCAFE_0001;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_rd_en = 1'b0;
    chk("R8 read old", NL'(cfg_rdata), NL'(mdl[1][2]));
    mdl[1][2] = 32'hCAFE_0001;
    rd(1, 2);
    chk("R8 read new", NL'(cfg_rdata), NL'(32'hCAFE_0001));

    // R9: independent banks
    for (int s = 0; s < 2; s++) for (int w = 0; w < NW; w++) wr(s, w, 32'h0);
    wr(0, 2, 32'h00FF_00FF);
    wr(1, 2, 32'h0F0F_0F0F);
    wr(0, 2, 32'h0);
    chk("R9 other bank kept", irq_out, exp_out());
    chk("R9 word2 lines", NL'(irq_out[95:64]), NL'(32'h0F0F_0F0F));

    // R1 again: reset clears masks and outputs
    irq_in = '0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < 2; s++) for (int w = 0; w < NW; w++) mdl[s][w] = '0;
    @(negedge clk);
    chk("R1 out after reset", irq_out, '0);
    check_all_words("R1 masks after reset");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule